// File: doc/BRIEF.md
# Circular Trace Buffer Write Sequencer

This block turns a stream of trace record words into memory writes spread across a ring of four equal-sized buffers, each with its own base address. Words fill buffer 0 from its base upward, four bytes per word, then buffer 1, buffer 2 and buffer 3. When buffer 3 is full and tracing is still enabled, writing continues from the base of buffer 0. Every time a buffer becomes full, the block reports it with a one-cycle event that carries the buffer index, so the downstream logic can drain that buffer while the next one fills.

Tracing is controlled by one enable level. When the enable rises, the block loads the four bases and the common buffer size, then begins at buffer 0, offset 0. When the enable falls, the record that is in progress is still written up to its last word, and then the block stops. If the current buffer holds data at that point, the block reports it with a stop event that gives the number of bytes written. A size input of zero selects the default size of 4 MiB. Each record is a run of words ended by a last marker. Records are expected to be 32-byte aligned units, so a record never crosses from one buffer into the next.

Top module: `trace_ring_dma`

## Requirements
- R1: After reset, wr_valid and done_valid are both 0, and no word is accepted until the enable has been seen high.
- R2: The first word after a start is written to the base of buffer 0. Each later word in the same buffer goes to the previous address plus 4, and wr_valid comes one cycle after the input word.
- R3: Buffers are used in the order 0, 1, 2, 3. The first word of buffer k is written to base k, which is bits [32k+31:32k] of base_flat.
- R4: After buffer 3 fills, writing continues at the base of buffer 0 while the enable stays high.
- R5: The word that fills a buffer (offset + 4 equals the size) raises done_valid for one cycle in the same cycle as its write. That event has done_partial = 0, done_idx = the buffer index and done_bytes = the buffer size.
- R6: If the enable falls inside a record, the rest of that record is still written, including the word with in_last = 1. Words that arrive after that are not written.
- R7: On a stop, a buffer holding at least one word gives one event with done_partial = 1, done_idx = the current buffer and done_bytes = the bytes written to it. If the stop follows a final word, the event comes with that word's write. If the enable falls between records, the event comes one cycle after the enable is seen low.
- R8: If the final word before a stop also fills its buffer, only the completion event (done_partial = 0) is raised and no stop event follows.
- R9: Raising the enable again after a stop restarts at buffer 0, offset 0, wherever the previous run ended.
- R10: The bases and the size are sampled when the enable is first seen high. Changing them during a run has no effect. A size of 0 means 4194304 bytes.
- R11: Words that arrive while the block is stopped produce no write and no event.
- R12: wr_data carries the accepted input word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_en | input | 1 | Tracing enable level |
| base_flat | input | NBUF*ADDR_W | Buffer base addresses, buffer k in slice k |
| buf_size | input | SIZE_W | Common buffer size in bytes, 0 selects 4 MiB |
| in_valid | input | 1 | Record word present |
| in_data | input | DATA_W | Record word |
| in_last | input | 1 | Final word of the record |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | DATA_W | Write data |
| done_valid | output | 1 | Buffer event pulse |
| done_idx | output | IDX_W | Buffer index of the event |
| done_partial | output | 1 | 1 for a stop event, 0 for a full buffer |
| done_bytes | output | SIZE_W | Bytes held by that buffer |

## Verification
Two things can fall in the same cycle: a buffer filling and a stop. The bench arranges this by dropping the enable partway through a record whose last word lands exactly on the end of buffer 0. It then expects a single full-buffer event on that write and checks that no stop event follows, either in that cycle or in the next. The other stop cases are run as well, a stop with the final word and a stop between records, and the bench checks in which cycle each partial report appears relative to the writes.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;

  localparam int unsigned WORD_BYTES    = 4;
  localparam int unsigned DEF_BUF_BYTES = 4194304;

  typedef enum logic {
    EV_FULL = 1'b0,
    EV_STOP = 1'b1
  } ev_kind_e;

endpackage

// File: rtl/trace_ring_cfg.sv
module trace_ring_cfg #(
  parameter int unsigned NBUF   = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [NBUF*ADDR_W-1:0] base_in,
  input  logic [SIZE_W-1:0]      size_in,
  output logic [NBUF*ADDR_W-1:0] base_q,
  output logic [SIZE_W-1:0]      size_q
);
  import trace_ring_pkg::*;

  localparam logic [SIZE_W-1:0] DEF_SIZE = SIZE_W'(DEF_BUF_BYTES);

  for (genvar g = 0; g < NBUF; g++) begin : g_base
    logic [ADDR_W-1:0] base_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        base_r <= '0;
      end else if (load) begin
        base_r <= base_in[g*ADDR_W +: ADDR_W];
      end
    end
    assign base_q[g*ADDR_W +: ADDR_W] = base_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= DEF_SIZE;
    end else if (load) begin
      size_q <= (size_in == '0) ? DEF_SIZE : size_in;
    end
  end

  assert_size_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
    size_q != '0);

endmodule

// File: rtl/trace_ring_seq.sv
module trace_ring_seq
  import trace_ring_pkg::*;
#(
  parameter int unsigned NBUF   = 4,
  parameter int unsigned SIZE_W = 32,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trace_en,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [SIZE_W-1:0] size_q,
  output logic              active,
  output logic              start,
  output logic              acc,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [SIZE_W-1:0] cur_off,
  output logic              ev_valid,
  output ev_kind_e          ev_kind,
  output logic [IDX_W-1:0]  ev_idx,
  output logic [SIZE_W-1:0] ev_bytes
);

  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NBUF - 1);
  localparam logic [SIZE_W-1:0] STEP     = SIZE_W'(WORD_BYTES);

  logic              mid;
  logic              mid_n;
  logic              fill;
  logic              stop;
  logic [SIZE_W-1:0] off_inc;
  logic [SIZE_W-1:0] off_after;

  always_comb begin
    start     = !active && trace_en;
    acc       = active && in_valid && (trace_en || mid);
    off_inc   = cur_off + STEP;
    fill      = acc && (off_inc == size_q);
    mid_n     = acc ? !in_last : mid;
    stop      = active && !trace_en && !mid_n;
    if (fill) begin
      off_after = '0;
    end else if (acc) begin
      off_after = off_inc;
    end else begin
      off_after = cur_off;
    end
    ev_valid  = fill || (stop && (off_after != '0));
    ev_kind   = fill ? EV_FULL : EV_STOP;
    ev_idx    = cur_idx;
    ev_bytes  = fill ? size_q : off_after;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      mid     <= 1'b0;
      cur_idx <= '0;
      cur_off <= '0;
    end else if (start) begin
      active  <= 1'b1;
      mid     <= 1'b0;
      cur_idx <= '0;
      cur_off <= '0;
    end else begin
      mid     <= mid_n;
      cur_off <= off_after;
      if (fill) begin
        cur_idx <= (cur_idx == LAST_IDX) ? '0 : cur_idx + 1'b1;
      end
      if (stop) begin
        active <= 1'b0;
      end
    end
  end

  assert_off_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    active |-> (cur_off < size_q) && (cur_off[1:0] == 2'b00));

  assert_ring_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    fill && (cur_idx == LAST_IDX) |=> cur_idx == '0);

  assert_stop_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> !mid && !$past(trace_en));

  assert_restart_origin_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> (cur_idx == '0) && (cur_off == '0));

endmodule

// File: rtl/trace_ring_out.sv
module trace_ring_out
  import trace_ring_pkg::*;
#(
  parameter int unsigned NBUF   = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SIZE_W = 32,
  parameter int unsigned IDX_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NBUF*ADDR_W-1:0] base_q,
  input  logic                   acc,
  input  logic [IDX_W-1:0]       cur_idx,
  input  logic [SIZE_W-1:0]      cur_off,
  input  logic [DATA_W-1:0]      in_data,
  input  logic                   ev_valid,
  input  ev_kind_e               ev_kind,
  input  logic [IDX_W-1:0]       ev_idx,
  input  logic [SIZE_W-1:0]      ev_bytes,
  output logic                   wr_valid,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [DATA_W-1:0]      wr_data,
  output logic                   done_valid,
  output logic [IDX_W-1:0]       done_idx,
  output logic                   done_partial,
  output logic [SIZE_W-1:0]      done_bytes
);

  logic [ADDR_W-1:0] sel_base;

  always_comb begin
    sel_base = base_q[cur_idx*ADDR_W +: ADDR_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid     <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
      done_valid   <= 1'b0;
      done_idx     <= '0;
      done_partial <= 1'b0;
      done_bytes   <= '0;
    end else begin
      wr_valid   <= acc;
      done_valid <= ev_valid;
      if (acc) begin
        wr_addr <= sel_base + ADDR_W'(cur_off);
        wr_data <= in_data;
      end
      if (ev_valid) begin
        done_idx     <= ev_idx;
        done_partial <= (ev_kind == EV_STOP);
        done_bytes   <= ev_bytes;
      end
    end
  end

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
    wr_valid && $past(wr_valid) && !$past(done_valid)
      |-> wr_addr == $past(wr_addr) + ADDR_W'(WORD_BYTES));

  assert_full_with_write_R5: assert property (@(posedge clk) disable iff (rst)
    done_valid && !done_partial |-> wr_valid);

  assert_partial_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
    done_valid && done_partial |-> done_bytes != '0);

endmodule

// File: rtl/trace_ring_dma.sv
module trace_ring_dma
  import trace_ring_pkg::*;
#(
  parameter int unsigned NBUF   = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SIZE_W = 32,
  parameter int unsigned IDX_W  = $clog2(NBUF)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   trace_en,
  input  logic [NBUF*ADDR_W-1:0] base_flat,
  input  logic [SIZE_W-1:0]      buf_size,
  input  logic                   in_valid,
  input  logic [DATA_W-1:0]      in_data,
  input  logic                   in_last,
  output logic                   wr_valid,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [DATA_W-1:0]      wr_data,
  output logic                   done_valid,
  output logic [IDX_W-1:0]       done_idx,
  output logic                   done_partial,
  output logic [SIZE_W-1:0]      done_bytes
);

  logic [NBUF*ADDR_W-1:0] base_q;
  logic [SIZE_W-1:0]      size_q;
  logic                   active;
  logic                   start;
  logic                   acc;
  logic [IDX_W-1:0]       cur_idx;
  logic [SIZE_W-1:0]      cur_off;
  logic                   ev_valid;
  ev_kind_e               ev_kind;
  logic [IDX_W-1:0]       ev_idx;
  logic [SIZE_W-1:0]      ev_bytes;

  trace_ring_cfg #(
    .NBUF(NBUF), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(start),
    .base_in(base_flat), .size_in(buf_size),
    .base_q(base_q), .size_q(size_q)
  );

  trace_ring_seq #(
    .NBUF(NBUF), .SIZE_W(SIZE_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst), .trace_en(trace_en),
    .in_valid(in_valid), .in_last(in_last), .size_q(size_q),
    .active(active), .start(start), .acc(acc),
    .cur_idx(cur_idx), .cur_off(cur_off),
    .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_idx(ev_idx), .ev_bytes(ev_bytes)
  );

  trace_ring_out #(
    .NBUF(NBUF), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SIZE_W(SIZE_W), .IDX_W(IDX_W)
  ) u_out (
    .clk(clk), .rst(rst), .base_q(base_q), .acc(acc),
    .cur_idx(cur_idx), .cur_off(cur_off), .in_data(in_data),
    .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_idx(ev_idx), .ev_bytes(ev_bytes),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .done_valid(done_valid), .done_idx(done_idx),
    .done_partial(done_partial), .done_bytes(done_bytes)
  );

  assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(active) |-> !wr_valid);

  assert_start_needs_enable_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(trace_en));

endmodule

// File: tb/trace_ring_dma_bench.sv
module trace_ring_dma_bench;

  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trace_en = 1'b0;
  logic [127:0]  base_flat = '0;
  logic [31:0]   buf_size = '0;
  logic          in_valid = 1'b0;
  logic [31:0]   in_data = '0;
  logic          in_last = 1'b0;
  logic          wr_valid;
  logic [31:0]   wr_addr;
  logic [31:0]   wr_data;
  logic          done_valid;
  logic [1:0]    done_idx;
  logic          done_partial;
  logic [31:0]   done_bytes;

  always #2.5 clk = ~clk;

  trace_ring_dma u_trace_ring_dma (
    .clk(clk), .rst(rst), .trace_en(trace_en), .base_flat(base_flat),
    .buf_size(buf_size), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .done_valid(done_valid), .done_idx(done_idx),
    .done_partial(done_partial), .done_bytes(done_bytes)
  );

  typedef struct {
    int unsigned cyc;
    bit          wv;
    logic [31:0] addr;
    logic [31:0] data;
    bit          dv;
    int unsigned idx;
    bit          part;
    logic [31:0] bytes;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  int unsigned cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;
  string       cur_req = "R1";

  bit          m_act = 0, m_mid = 0;
  int unsigned m_buf = 0, m_off = 0, m_sz = 0;
  logic [31:0] m_base [NB];
  logic [31:0] dctr = 32'hA500_0000;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Monitor: compares outputs against the scoreboard queue.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
        chk(0, exp_q[0].tag, "missing output", 32'(cyc), 32'(exp_q[0].cyc));
        void'(exp_q.pop_front());
      end
      if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(wr_valid == e.wv, e.tag, "wr_valid", 32'(wr_valid), 32'(e.wv));
        if (e.wv) begin
          chk(wr_addr == e.addr, e.tag, "wr_addr", wr_addr, e.addr);
          chk(wr_data == e.data, e.tag, "wr_data", wr_data, e.data);
        end
        chk(done_valid == e.dv, e.tag, "done_valid", 32'(done_valid), 32'(e.dv));
        if (e.dv) begin
          chk(32'(done_idx) == e.idx, e.tag, "done_idx", 32'(done_idx), e.idx);
          chk(done_partial == e.part, e.tag, "done_partial",
              32'(done_partial), 32'(e.part));
          chk(done_bytes == e.bytes, e.tag, "done_bytes", done_bytes, e.bytes);
        end
      end else if (wr_valid || done_valid) begin
        chk(0, cur_req, "unexpected output", {wr_valid, 15'd0, done_valid, 15'd0}, 32'd0);
      end
    end
  end

  // Driver: one cycle of stimulus plus the expected result from the model.
  task automatic tick(input bit en, input bit v, input bit l);
    exp_t e;
    bit   acc;
    bit   was_act;
    logic [31:0] d;
    d = dctr;
    if (v) dctr = dctr + 32'h0001_0003;
    trace_en = en; in_valid = v; in_data = d; in_last = l;
    e.cyc = cyc + 1; e.wv = 0; e.addr = '0; e.data = '0; e.dv = 0;
    e.idx = 0; e.part = 0; e.bytes = '0; e.tag = cur_req;
    was_act = m_act;
    acc = m_act && v && (en || m_mid);
    if (acc) begin
      e.wv = 1; e.addr = m_base[m_buf] + m_off; e.data = d;
      m_off = m_off + 4;
      m_mid = !l;
      if (m_off == m_sz) begin
        e.dv = 1; e.idx = m_buf; e.part = 0; e.bytes = m_sz;
        m_buf = (m_buf + 1) % NB; m_off = 0;
      end
    end
    if (m_act && !en && !m_mid) begin
      m_act = 0;
      if (m_off != 0) begin
        e.dv = 1; e.idx = m_buf; e.part = 1; e.bytes = m_off;
      end
    end
    if (!was_act && en) begin
      m_act = 1; m_buf = 0; m_off = 0; m_mid = 0;
      for (int i = 0; i < NB; i++) m_base[i] = base_flat[i*32 +: 32];
      m_sz = (buf_size == 0) ? 4194304 : buf_size;
    end
    if (e.wv || e.dv) exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic words(input int n, input bit en);
    for (int i = 0; i < n; i++) tick(en, 1'b1, (i % 8) == 7);
  endtask

  task automatic set_bases(input logic [31:0] b0, input logic [31:0] b1,
                           input logic [31:0] b2, input logic [31:0] b3);
    base_flat = {b3, b2, b1, b0};
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    set_bases(32'h1000_0000, 32'h2000_0100, 32'h3000_0040, 32'h0000_8000);
    buf_size = 32'd64;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state of the outputs
    chk(!wr_valid && !done_valid, "R1", "outputs after reset",
        {31'd0, wr_valid | done_valid}, 32'd0);

    // R11: words while stopped are ignored
    cur_req = "R11";
    words(3, 1'b0);
    tick(1'b0, 1'b0, 1'b0);

    // R2 R3 R4 R5 R12: full ring plus wrap into buffer 0
    cur_req = "R3";
    tick(1'b1, 1'b0, 1'b0);
    words(64, 1'b1);
    cur_req = "R4";
    words(8, 1'b1);
    // R7: enable dropped between records, report one cycle later
    cur_req = "R7";
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);

    // R9 R6: restart, drop enable inside a record in buffer 1
    cur_req = "R9";
    set_bases(32'h1100_0000, 32'h2200_0000, 32'h3300_0000, 32'h4400_0000);
    tick(1'b1, 1'b0, 1'b0);
    words(16, 1'b1);
    cur_req = "R6";
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b1, i == 4);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 1'b0);
    tick(1'b0, 1'b0, 1'b0);

    // R8: stop coincides with buffer 0 filling
    cur_req = "R8";
    tick(1'b1, 1'b0, 1'b0);
    words(8, 1'b1);
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b1, i == 4);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);

    // R10: inputs changed during a run are ignored
    cur_req = "R10";
    tick(1'b1, 1'b0, 1'b0);
    words(8, 1'b1);
    buf_size = 32'd32;
    set_bases(32'h7700_0000, 32'h7800_0000, 32'h7900_0000, 32'h7A00_0000);
    words(8, 1'b1);
    tick(1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0);

    // R10: size 0 selects 4 MiB, no completion after 96 bytes
    buf_size = 32'd0;
    tick(1'b1, 1'b0, 1'b0);
    words(24, 1'b1);
    tick(1'b0, 1'b0, 1'b0);
    repeat (3) tick(1'b0, 1'b0, 1'b0);

    chk(exp_q.size() == 0, cur_req, "leftover expected items",
        32'(exp_q.size()), 32'd0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule